// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block turns one logical block write into the physical read-modify-write traffic needed on a five-column disk array with rotating parity. The host offers a logical block number and a 32-bit data word on a valid/ready handshake. The engine finds the stripe, the data column and the parity column for that block. It then drives a single-request disk port through two reads and two writes, so that the data block and its parity block are both updated.

The disk port carries a one-cycle request strobe with a direction bit, a column, a stripe and write data. The disk answers each request with a one-cycle done strobe, which carries read data on reads. Only one access is in flight at a time. While a logical write is under way the host handshake is closed. When the final access completes, a one-cycle completion pulse is raised.

Top module: `parity_rmw_engine`

## Requirements
- R1: The stripe index of a logical block number is the number divided by 4, and its position inside the stripe is the number modulo 4; every access of a logical write carries that stripe on `dk_stripe`.
- R2: The parity column of stripe s is 4 minus (s mod 5), so parity sits in column 4 for stripe 0, column 3 for stripe 1, and so on.
- R3: The data column equals the position when the position is below the parity column, and the position plus 1 otherwise.
- R4: Each logical write issues exactly four accesses in this order: read data column (`dk_write`=0), read parity column (`dk_write`=0), write data column (`dk_write`=1), write parity column (`dk_write`=1).
- R5: `dk_req` is a one-cycle strobe, and no new request is issued until `dk_done` has answered the previous one. Column, direction and stripe stay steady while a request is outstanding.
- R6: The data write carries the host's word unchanged on `dk_wdata`.
- R7: The parity write carries old data XOR new data XOR old parity, so the XOR of all five blocks of the stripe stays zero.
- R8: `wr_ready` is high when the engine is idle. It is low from the cycle after a write is accepted until the parity write's `dk_done` has been taken.
- R9: `wr_done` is high for exactly one cycle, in the cycle after the `dk_done` of the parity write, and `wr_ready` is high in that same cycle.
- R10: During and after reset, `wr_ready` is 1, `dk_req` is 0 and `wr_done` is 0. With `wr_valid` low the engine issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host offers a logical write |
| wr_ready | output | 1 | Engine can accept a logical write |
| wr_lbn | input | 16 | Logical block number |
| wr_data | input | 32 | New block word |
| wr_done | output | 1 | One-cycle completion pulse |
| dk_req | output | 1 | One-cycle physical access strobe |
| dk_write | output | 1 | 1 = physical write, 0 = physical read |
| dk_col | output | 3 | Column (disk) addressed |
| dk_stripe | output | 14 | Stripe addressed |
| dk_wdata | output | 32 | Write word (zero on reads) |
| dk_rdata | input | 32 | Read word, valid with dk_done |
| dk_done | input | 1 | Access completed |

## Verification
The assertions assume that the disk side answers each request with exactly one `dk_done` pulse, that this pulse comes at least one cycle after the strobe, and that no `dk_done` arrives while nothing is outstanding. The bench's disk model keeps to this. It samples `dk_req` between clock edges and raises `dk_done` for a single cycle after a latency of one to three cycles, which it rotates from one access to the next. The host side offers a new write only when `wr_ready` is seen high. The sweep covers every logical block of two full parity rotations, plus blocks at the top of the number range.

// File: rtl/raid5_pkg.sv
package raid5_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  // access step codes: bit 1 = write, bit 0 = parity column
  localparam logic [1:0] STEP_RD_DATA = 2'd0;
  localparam logic [1:0] STEP_RD_PAR  = 2'd1;
  localparam logic [1:0] STEP_WR_DATA = 2'd2;
  localparam logic [1:0] STEP_WR_PAR  = 2'd3;

  // parity moves one column left per stripe
  function automatic int parity_col_of(input int stripe, input int ncols);
    return ncols - 1 - (stripe % ncols);
  endfunction

  // data positions fill columns left to right, hopping over parity
  function automatic int data_col_of(input int pos, input int pcol);
    return (pos >= pcol) ? pos + 1 : pos;
  endfunction

endpackage

// File: rtl/stripe_mapper.sv
module stripe_mapper #(
  parameter int NUM_COLS = 5,
  parameter int LBN_W    = 16,
  localparam int DPS      = NUM_COLS - 1,
  localparam int POS_W    = $clog2(DPS),
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int STRIPE_W = LBN_W - POS_W
) (
  input  logic [LBN_W-1:0]    lbn,
  output logic [STRIPE_W-1:0] stripe,
  output logic [COL_W-1:0]    data_col,
  output logic [COL_W-1:0]    par_col
);
  import raid5_pkg::*;

  logic [POS_W-1:0] pos;

  always_comb begin
    stripe   = STRIPE_W'(lbn / DPS);
    pos      = POS_W'(lbn % DPS);
    par_col  = COL_W'(parity_col_of(int'(stripe), NUM_COLS));
    data_col = COL_W'(data_col_of(int'(pos), int'(par_col)));
  end

endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_valid,
  input  logic       acc_done,
  output logic       idle,
  output logic       accept_evt,
  output logic       issue_evt,
  output logic       done_evt,
  output logic [1:0] step,
  output logic       finish_pulse
);
  import raid5_pkg::*;

  phase_e     phase_q;
  logic [1:0] step_q;
  logic       finish_q;

  assign idle       = (phase_q == PH_IDLE);
  assign accept_evt = idle && host_valid;
  assign issue_evt  = (phase_q == PH_ISSUE);
  assign done_evt   = (phase_q == PH_WAIT) && acc_done;
  assign step       = step_q;
  assign finish_pulse = finish_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      step_q   <= STEP_RD_DATA;
      finish_q <= 1'b0;
    end else begin
      finish_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (host_valid) begin
            step_q  <= STEP_RD_DATA;
            phase_q <= PH_ISSUE;
          end
        end
        PH_ISSUE: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (acc_done) begin
            if (step_q == STEP_WR_PAR) begin
              phase_q  <= PH_IDLE;
              finish_q <= 1'b1;
            end else begin
              step_q  <= step_q + 2'd1;
              phase_q <= PH_ISSUE;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/parity_accum.sv
module parity_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] new_in,
  input  logic              fold,
  input  logic [DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0] new_q,
  output logic [DATA_W-1:0] acc_q
);

  function automatic logic [DATA_W-1:0] fold_word(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    return a ^ b;
  endfunction

  // acc starts as new data, then absorbs old data and old parity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      new_q <= new_in;
      acc_q <= new_in;
    end else if (fold) begin
      acc_q <= fold_word(acc_q, rd_in);
    end
  end

endmodule

// File: rtl/parity_rmw_engine.sv
module parity_rmw_engine #(
  parameter int NUM_COLS = 5,
  parameter int DATA_W   = 32,
  parameter int LBN_W    = 16,
  localparam int DPS      = NUM_COLS - 1,
  localparam int POS_W    = $clog2(DPS),
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int STRIPE_W = LBN_W - POS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [LBN_W-1:0]    wr_lbn,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_done,
  output logic                dk_req,
  output logic                dk_write,
  output logic [COL_W-1:0]    dk_col,
  output logic [STRIPE_W-1:0] dk_stripe,
  output logic [DATA_W-1:0]   dk_wdata,
  input  logic [DATA_W-1:0]   dk_rdata,
  input  logic                dk_done
);

  logic                idle;
  logic                accept_evt;
  logic                issue_evt;
  logic                done_evt;
  logic [1:0]          step;
  logic                fold_evt;
  logic [LBN_W-1:0]    lbn_q;
  logic [STRIPE_W-1:0] map_stripe;
  logic [COL_W-1:0]    map_dcol;
  logic [COL_W-1:0]    map_pcol;
  logic [DATA_W-1:0]   new_q;
  logic [DATA_W-1:0]   acc_q;

  rmw_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_valid   (wr_valid),
    .acc_done     (dk_done),
    .idle         (idle),
    .accept_evt   (accept_evt),
    .issue_evt    (issue_evt),
    .done_evt     (done_evt),
    .step         (step),
    .finish_pulse (wr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lbn_q <= '0;
    else if (accept_evt) lbn_q <= wr_lbn;
  end

  stripe_mapper #(
    .NUM_COLS (NUM_COLS),
    .LBN_W    (LBN_W)
  ) u_map (
    .lbn      (lbn_q),
    .stripe   (map_stripe),
    .data_col (map_dcol),
    .par_col  (map_pcol)
  );

  // old data and old parity are both folded in (read steps only)
  assign fold_evt = done_evt && !step[1];

  parity_accum #(
    .DATA_W (DATA_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_evt),
    .new_in (wr_data),
    .fold   (fold_evt),
    .rd_in  (dk_rdata),
    .new_q  (new_q),
    .acc_q  (acc_q)
  );

  assign wr_ready  = idle;
  assign dk_req    = issue_evt;
  assign dk_write  = step[1];
  assign dk_col    = step[0] ? map_pcol : map_dcol;
  assign dk_stripe = map_stripe;
  assign dk_wdata  = !step[1] ? '0 : (step[0] ? acc_q : new_q);

endmodule

// File: rtl/parity_rmw_chk.sv
module parity_rmw_chk #(
  parameter int DATA_W = 32,
  parameter int COL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept_evt,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              wr_done,
  input logic              dk_req,
  input logic              dk_write,
  input logic [COL_W-1:0]  dk_col,
  input logic [DATA_W-1:0] dk_wdata,
  input logic [DATA_W-1:0] dk_rdata,
  input logic              dk_done
);

  logic              outstanding;
  logic [1:0]        req_cnt;
  logic [1:0]        done_cnt;
  logic [COL_W-1:0]  first_col;
  logic [COL_W-1:0]  second_col;
  logic [DATA_W-1:0] cap_new;
  logic [DATA_W-1:0] cap_old_d;
  logic [DATA_W-1:0] cap_old_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      req_cnt     <= '0;
      done_cnt    <= '0;
      first_col   <= '0;
      second_col  <= '0;
      cap_new     <= '0;
      cap_old_d   <= '0;
      cap_old_p   <= '0;
    end else begin
      if (accept_evt) cap_new <= wr_data;
      if (dk_req) begin
        outstanding <= 1'b1;
        req_cnt     <= req_cnt + 2'd1;
        if (req_cnt == 2'd0) first_col  <= dk_col;
        if (req_cnt == 2'd1) second_col <= dk_col;
      end else if (dk_done) begin
        outstanding <= 1'b0;
      end
      if (dk_done && outstanding) begin
        done_cnt <= done_cnt + 2'd1;
        if (done_cnt == 2'd0) cap_old_d <= dk_rdata;
        if (done_cnt == 2'd1) cap_old_p <= dk_rdata;
      end
    end
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req |-> !outstanding);

  // R5
  fields_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> ($stable(dk_col) && $stable(dk_write)));

  // R4
  access_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req |-> (dk_write == req_cnt[1]));

  // R4
  column_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dk_req && req_cnt == 2'd1) |-> (dk_col != first_col));

  // R4
  write_columns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dk_req && req_cnt[1]) |-> (dk_col == (req_cnt[0] ? second_col : first_col)));

  // R6
  data_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dk_req && req_cnt == 2'd2) |-> (dk_wdata == cap_new));

  // R7
  parity_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dk_req && req_cnt == 2'd3) |-> (dk_wdata == (cap_new ^ cap_old_d ^ cap_old_p)));

  // R8
  ready_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !wr_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (wr_ready && $past(dk_done) && done_cnt == 2'd0));

endmodule

bind parity_rmw_engine parity_rmw_chk #(
  .DATA_W (DATA_W),
  .COL_W  (COL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_evt (accept_evt),
  .wr_data    (wr_data),
  .wr_ready   (wr_ready),
  .wr_done    (wr_done),
  .dk_req     (dk_req),
  .dk_write   (dk_write),
  .dk_col     (dk_col),
  .dk_wdata   (dk_wdata),
  .dk_rdata   (dk_rdata),
  .dk_done    (dk_done)
);

// File: tb/parity_rmw_engine_test.sv
`timescale 1ns/1ps
module parity_rmw_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_lbn = '0;
  logic [31:0] wr_data = '0;
  logic        wr_done;
  logic        dk_req;
  logic        dk_write;
  logic [2:0]  dk_col;
  logic [13:0] dk_stripe;
  logic [31:0] dk_wdata;
  logic [31:0] dk_rdata = '0;
  logic        dk_done = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  // disk model and access log
  logic [31:0] disk [int];
  int          nlog = 0;
  int          acc_num = 0;
  int          overlap_bad = 0;
  int          last_done_cyc = 0;
  logic        log_wr  [8];
  int          log_col [8];
  int          log_str [8];
  logic [31:0] log_wd  [8];

  parity_rmw_engine uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_lbn(wr_lbn), .wr_data(wr_data),
    .wr_done(wr_done),
    .dk_req(dk_req), .dk_write(dk_write), .dk_col(dk_col), .dk_stripe(dk_stripe),
    .dk_wdata(dk_wdata), .dk_rdata(dk_rdata), .dk_done(dk_done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic int key_of(input int s, input int c);
    return s * 8 + c;
  endfunction

  function automatic logic [31:0] rd_model(input int k);
    return disk.exists(k) ? disk[k] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // disk responder: one access at a time, latency 1..3 cycles
  initial begin
    forever begin
      @(negedge clk);
      dk_done = 1'b0;
      if (dk_req) begin
        int k;
        int lat;
        if (nlog < 8) begin
          log_wr[nlog]  = dk_write;
          log_col[nlog] = int'(dk_col);
          log_str[nlog] = int'(dk_stripe);
          log_wd[nlog]  = dk_wdata;
        end
        nlog++;
        k = key_of(int'(dk_stripe), int'(dk_col));
        lat = acc_num % 3;
        acc_num++;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (dk_req) overlap_bad++;
        end
        @(negedge clk);
        if (dk_req) overlap_bad++;
        if (dk_write) begin
          disk[k] = dk_wdata;
          dk_rdata = 32'hDEAD_BEEF;
        end else begin
          dk_rdata = rd_model(k);
        end
        dk_done = 1'b1;
        last_done_cyc = cyc_cnt;
      end
    end
  end

  task automatic do_write(input int lbn, input logic [31:0] data);
    int s, pos, pc, dc, cyc, busy_bad;
    logic [31:0] old_d, old_p, exp_p, sx;
    s   = lbn / 4;
    pos = lbn % 4;
    pc  = 4 - (s % 5);
    dc  = (pos < pc) ? pos : pos + 1;
    old_d = rd_model(key_of(s, dc));
    old_p = rd_model(key_of(s, pc));
    exp_p = old_d ^ data ^ old_p;

    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    nlog = 0;
    overlap_bad = 0;
    wr_valid = 1'b1;
    wr_lbn = 16'(lbn);
    wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
    cyc = 0;
    busy_bad = 0;
    while (!wr_done && cyc < 1000) begin
      if (wr_ready) busy_bad++;
      @(negedge clk);
      cyc++;
    end
    chk(busy_bad == 0, "R8 ready low while busy", busy_bad, 0);
    chk(wr_ready == 1'b1, "R9 ready high with done", wr_ready, 1);
    chk(cyc_cnt == last_done_cyc + 1, "R9 done one cycle after last access", cyc_cnt, last_done_cyc + 1);
    chk(overlap_bad == 0, "R5 single outstanding access", overlap_bad, 0);
    chk(nlog == 4, "R4 access count", nlog, 4);
    if (nlog == 4) begin
      chk(log_wr[0] == 0 && log_wr[1] == 0 && log_wr[2] == 1 && log_wr[3] == 1,
          "R4 read-read-write-write", {log_wr[0], log_wr[1], log_wr[2], log_wr[3]}, 4'b0011);
      for (int i = 0; i < 4; i++)
        chk(log_str[i] == s, "R1 stripe", log_str[i], s);
      chk(log_col[1] == pc && log_col[3] == pc, "R2 parity column", log_col[3], pc);
      chk(log_col[0] == dc && log_col[2] == dc, "R3 data column", log_col[2], dc);
      chk(log_wd[2] == data, "R6 data word", log_wd[2], data);
      chk(log_wd[3] == exp_p, "R7 parity word", log_wd[3], exp_p);
    end
    sx = 32'h0;
    for (int c = 0; c < 5; c++) sx ^= rd_model(key_of(s, c));
    chk(sx == 32'h0, "R7 stripe XOR zero", sx, 0);
    chk(rd_model(key_of(s, dc)) == data, "R6 block holds new data", rd_model(key_of(s, dc)), data);
    @(negedge clk);
    chk(wr_done == 1'b0, "R9 done single cycle", wr_done, 0);
  endtask

  initial begin
    // preload ten stripes with consistent parity
    for (int s = 0; s < 10; s++) begin
      logic [31:0] x;
      int pc;
      x = 32'h0;
      pc = 4 - (s % 5);
      for (int c = 0; c < 5; c++) begin
        if (c != pc) begin
          disk[key_of(s, c)] = 32'h3C00_0000 ^ (32'(s) * 32'h0001_0203) ^ (32'(c) << 20);
          x ^= disk[key_of(s, c)];
        end
      end
      disk[key_of(s, pc)] = x;
    end

    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b1, "R10 reset ready", wr_ready, 1);
    chk(dk_req == 1'b0, "R10 reset no request", dk_req, 0);
    chk(wr_done == 1'b0, "R10 reset no done", wr_done, 0);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (dk_req || wr_done || !wr_ready) seen++;
      end
      chk(seen == 0, "R10 idle without valid", seen, 0);
    end

    // two full parity rotations, every block
    for (int lbn = 0; lbn < 40; lbn++)
      do_write(lbn, 32'hA500_0000 ^ (32'(lbn) * 32'h0101_0101 + 32'd7));
    // rewrite with same data and with all-ones
    do_write(13, 32'hA500_0000 ^ (32'd13 * 32'h0101_0101 + 32'd7));
    do_write(22, 32'hFFFF_FFFF);
    do_write(22, 32'h0000_0000);
    // top of the number range
    do_write(65535, 32'h1357_9BDF);
    do_write(65532, 32'h2468_ACE0);
    do_write(65534, 32'h0F0F_0F0F);
    do_write(40960, 32'h8000_0001);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, 0);
    summary();
  end

endmodule